// File: doc/BRIEF.md
# Frame Pixel Grabber Register

The grabber samples a streamed image one pixel per frame, so a host that can only poll a single 8-bit register can, over many frames, upload a full 15x15 image. A pixel stream presents 7-bit pixels together with their position index and a valid qualifier. A one-cycle pulse marks the start of each frame. The block keeps a target index. When capture is armed and the streamed index equals the target, it latches that pixel and raises a ready flag. The held pixel stays put, through any number of later frames, until the host reads it.

The host sees one register value. Bit 7 is the ready flag and bits 6:0 are the held pixel. A read strobe while the flag is set consumes the pixel, steps the target index (224 wraps to 0) and re-arms capture. A read while the flag is clear changes nothing. A write strobe restarts the upload: the target goes back to pixel 0, any held pixel is dropped, and capture waits for the next frame start.

Top module: `pixel_grabber`

## Requirements
- R1: After reset the register value is 0x00 and the first pixel captured is index 0; capture is already allowed in the frame under way.
- R2: When the ready flag is clear and capture is allowed, a valid stream pixel whose index equals the target is latched: from the next cycle bit 7 is 1 and bits 6:0 equal that pixel.
- R3: At most one pixel is captured per frame; after a capture, no further pixel is taken until the next frame-start pulse, even if the host reads and re-arms within the frame.
- R4: While the ready flag is set and neither strobe is active, the register value does not change, whatever the stream carries and however many frames pass.
- R5: A read strobe while bit 7 is 1 returns the held value in that cycle; from the next cycle the register reads 0x00 and the target index is one higher.
- R6: A read strobe while bit 7 is 0 returns 0x00 and leaves the target index unchanged.
- R7: The target index stays below the pixel count; after a consumed read of the last pixel (224), the target becomes 0.
- R8: A write strobe sets the target index to 0, clears the register to 0x00, and blocks capture until the next frame-start pulse. A write takes priority over a read or a capture in the same cycle.
- R9: A stream pixel that arrives in the same cycle as the frame-start pulse belongs to the new frame and can be captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse on the first cycle of a frame |
| pix_valid | input | 1 | Stream pixel qualifier |
| pix_idx | input | IDX_W (8) | Position of the streamed pixel, 0 to NUM_PIX-1 |
| pix_data | input | PIX_W (7) | Streamed pixel value |
| rd_strobe | input | 1 | Host read of the register in this cycle |
| wr_strobe | input | 1 | Host write of the register in this cycle |
| reg_value | output | PIX_W+1 (8) | {ready flag, held pixel}; 0x00 when empty |

## Verification
The bench builds the block with its default of 225 pixels per frame and 7-bit pixels. With that full-size image it streams every index in each frame and can run one complete upload of 225 consumed reads. That run carries the target across the 224-to-0 wrap. Each read is compared against a reference model. The fixed cases place a read inside a frame after a capture, a write on the same cycle as a read of a held pixel, and a pixel on the same cycle as the frame-start pulse.

// File: rtl/pg_pkg.sv
// Shared definitions for the frame pixel grabber.
// Assumes: nothing beyond the standard types.
package pg_pkg;

    // Capture permission for the frame in progress.
    typedef enum logic {
        GATE_OPEN = 1'b0,   // a capture may still happen in this frame
        GATE_SHUT = 1'b1    // capture already used or write pending a frame start
    } gate_e;

    // Bit position of the ready flag within the register value.
    function automatic int flag_pos(input int pix_w);
        return pix_w;
    endfunction

endpackage

// File: rtl/pg_index_ctr.sv
// Target pixel index for the grabber.
// Counts 0 .. NUM_PIX-1 and wraps; a clear forces 0 and wins over an advance.
// Assumes: advance is only raised when a held pixel is consumed.
module pg_index_ctr #(
    parameter int NUM_PIX = 225,
    localparam int IDX_W = $clog2(NUM_PIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PIX - 1);

    logic [IDX_W-1:0] idx_q;

    // Hold, restart or step the target index.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            idx_q <= '0;
        end else if (advance) begin
            if (idx_q == LAST_IDX) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign idx_o = idx_q;

endmodule

// File: rtl/pg_frame_gate.sv
// One-capture-per-frame gate.
// Shuts when a capture or a write happens; reopens on the frame-start pulse.
// A pixel in the same cycle as the frame start already sees the gate open.
// Assumes: frame_start is a single-cycle pulse.
module pg_frame_gate
    import pg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic shut_req,
    output logic open_o
);

    gate_e gate_q;

    // Track whether this frame may still yield a capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= GATE_OPEN;
        end else if (shut_req) begin
            gate_q <= GATE_SHUT;
        end else if (frame_start) begin
            gate_q <= GATE_OPEN;
        end
    end

    // A new frame opens the gate in its own first cycle.
    assign open_o = (gate_q == GATE_OPEN) || frame_start;

endmodule

// File: rtl/pg_capture_reg.sv
// Holding register for one captured pixel plus its ready flag.
// Clear wins over take; take and consume never coincide (take needs empty).
// Data reads as zero whenever the flag is clear.
// Assumes: the caller only raises take while full_o is low.
module pg_capture_reg #(
    parameter int PIX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             take,
    input  logic             consume,
    input  logic [PIX_W-1:0] data_in,
    output logic             full_o,
    output logic [PIX_W-1:0] data_o
);

    logic             full_q;
    logic [PIX_W-1:0] data_q;

    // Latch, drop or hold the captured pixel.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b1;
            data_q <= data_in;
        end else if (consume) begin
            full_q <= 1'b0;
            data_q <= '0;
        end
    end

    assign full_o = full_q;
    assign data_o = data_q;

endmodule

// File: rtl/pixel_grabber.sv
// Frame pixel grabber: samples one streamed pixel per frame at a self-advancing
// target index and presents it as {ready, pixel} to a host register port.
// Assumes: pix_idx < NUM_PIX whenever pix_valid is high; strobes last one cycle
// per access.
module pixel_grabber
    import pg_pkg::*;
#(
    parameter int NUM_PIX = 225,
    parameter int PIX_W = 7,
    localparam int IDX_W = $clog2(NUM_PIX),
    localparam int REG_W = PIX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             pix_valid,
    input  logic [IDX_W-1:0] pix_idx,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             rd_strobe,
    input  logic             wr_strobe,
    output logic [REG_W-1:0] reg_value
);

    localparam int FLAG_BIT = flag_pos(PIX_W);

    logic [IDX_W-1:0] idx_q;
    logic             gate_open;
    logic             full;
    logic [PIX_W-1:0] held;
    logic             take;
    logic             consume;

    // Capture when armed, gated for this frame, and the stream hits the target.
    assign take    = !wr_strobe && !full && gate_open && pix_valid && (pix_idx == idx_q);
    // A read only counts when a pixel is actually held.
    assign consume = !wr_strobe && rd_strobe && full;

    pg_index_ctr #(
        .NUM_PIX (NUM_PIX)
    ) u_idx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wr_strobe),
        .advance (consume),
        .idx_o   (idx_q)
    );

    pg_frame_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .shut_req    (take || wr_strobe),
        .open_o      (gate_open)
    );

    pg_capture_reg #(
        .PIX_W (PIX_W)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (wr_strobe),
        .take    (take),
        .consume (consume),
        .data_in (pix_data),
        .full_o  (full),
        .data_o  (held)
    );

    // Assemble the host-visible register value.
    always_comb begin
        reg_value           = '0;
        reg_value[FLAG_BIT] = full;
        reg_value[PIX_W-1:0] = held;
    end

endmodule

// File: rtl/pixel_grabber_chk.sv
// Property checker for pixel_grabber, attached by bind.
// Assumes: cur_idx is the target index register of the grabber.
module pixel_grabber_chk #(
    parameter int NUM_PIX = 225,
    parameter int PIX_W = 7,
    localparam int IDX_W = $clog2(NUM_PIX),
    localparam int REG_W = PIX_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pix_valid,
    input logic [IDX_W-1:0] pix_idx,
    input logic [PIX_W-1:0] pix_data,
    input logic             rd_strobe,
    input logic             wr_strobe,
    input logic [REG_W-1:0] reg_value,
    input logic [IDX_W-1:0] cur_idx
);

    AST_CAP_MATCHES_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_value[PIX_W]) |-> ($past(pix_valid) && reg_value[PIX_W-1:0] == $past(pix_data) && $past(pix_idx) == cur_idx)); // R2

    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_value[PIX_W] && !rd_strobe && !wr_strobe) |=> $stable(reg_value)); // R4

    AST_READ_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_value[PIX_W] && rd_strobe && !wr_strobe) |=> (reg_value == '0)); // R5

    AST_EMPTY_IDX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_value[PIX_W] && !wr_strobe) |=> $stable(cur_idx)); // R6

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_idx < IDX_W'(NUM_PIX)); // R7

    AST_IDX_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_value[PIX_W] && rd_strobe && !wr_strobe && cur_idx == IDX_W'(NUM_PIX - 1)) |=> (cur_idx == '0)); // R7

    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> (reg_value == '0 && cur_idx == '0)); // R8

endmodule

bind pixel_grabber pixel_grabber_chk #(
    .NUM_PIX (NUM_PIX),
    .PIX_W   (PIX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_idx   (pix_idx),
    .pix_data  (pix_data),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .reg_value (reg_value),
    .cur_idx   (idx_q)
);

// File: tb/pixel_grabber_tb.sv
// Scoreboard bench for pixel_grabber: the driver updates a reference model and
// queues the expected value of every read; the monitor compares on each read.
module pixel_grabber_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_PIX = 225;
    localparam int PIX_W = 7;
    localparam int IDX_W = $clog2(NUM_PIX);
    localparam int REG_W = PIX_W + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic             pix_valid = 1'b0;
    logic [IDX_W-1:0] pix_idx = '0;
    logic [PIX_W-1:0] pix_data = '0;
    logic             rd_strobe = 1'b0;
    logic             wr_strobe = 1'b0;
    logic [REG_W-1:0] reg_value;

    int n_checks = 0;
    int n_fails = 0;
    bit finished = 1'b0;

    logic [REG_W-1:0] exp_q[$];
    string            tag_q[$];

    // reference model state
    int               m_idx = 0;
    bit               m_full = 1'b0;
    logic [PIX_W-1:0] m_data = '0;
    bit               m_shut = 1'b0;

    pixel_grabber #(.NUM_PIX(NUM_PIX), .PIX_W(PIX_W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pix_valid   (pix_valid),
        .pix_idx     (pix_idx),
        .pix_data    (pix_data),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe),
        .reg_value   (reg_value)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [PIX_W-1:0] pix_fn(input int f, input int i);
        return PIX_W'((f * 13 + i * 5 + 1) % 128);
    endfunction

    task automatic report(input string tag, input logic [REG_W-1:0] act, input logic [REG_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: reg_value actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus; the model applies the requirements' priorities.
    task automatic step(input bit fs, input bit pv, input int pi, input logic [PIX_W-1:0] pd,
                        input bit rd, input bit wr, input string tag);
        bit cap;
        frame_start = fs;
        pix_valid   = pv;
        pix_idx     = IDX_W'(pi);
        pix_data    = pd;
        rd_strobe   = rd;
        wr_strobe   = wr;
        if (rd) begin
            exp_q.push_back(m_full ? {1'b1, m_data} : '0);
            tag_q.push_back(tag);
        end
        if (wr) begin                                   // R8 write wins
            m_idx = 0; m_full = 1'b0; m_data = '0; m_shut = 1'b1;
        end else begin
            cap = !m_full && (!m_shut || fs) && pv && (pi == m_idx);
            if (m_full && rd) begin                     // R5, R7
                m_full = 1'b0; m_data = '0;
                m_idx = (m_idx == NUM_PIX - 1) ? 0 : m_idx + 1;
            end
            if (fs) m_shut = 1'b0;                       // R9
            if (cap) begin                               // R2, R3
                m_full = 1'b1; m_data = pd; m_shut = 1'b1;
            end
        end
        @(negedge clk);
    endtask

    task automatic frame(input int f, input string tag);
        for (int i = 0; i < NUM_PIX; i++) step(i == 0, 1'b1, i, pix_fn(f, i), 1'b0, 1'b0, tag);
    endtask

    task automatic rd_only(input string tag);
        step(1'b0, 1'b0, 0, '0, 1'b1, 1'b0, tag);
    endtask

    // Monitor: compare every read against the queued expectation.
    always begin
        @(negedge clk);
        #(CLK_PERIOD / 4);
        if (rd_strobe) begin
            if (exp_q.size() == 0) begin
                report("unexpected read", reg_value, '0);
            end else begin
                report(tag_q.pop_front(), reg_value, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(CLK_PERIOD / 4);
        report("R1 reset value", reg_value, '0);
        @(negedge clk);

        // R1/R2: first frame captures index 0
        frame(1, "R2");
        rd_only("R1 R2 first capture is pixel 0");
        rd_only("R5 consumed register reads empty");
        rd_only("R6 empty read");
        // R6: index unchanged by empty reads, so index 1 comes next
        frame(2, "R6");
        rd_only("R6 index kept after empty reads");

        // R3: capture idx 2, read mid-frame, later idx 3 must not be taken
        step(1'b1, 1'b1, 0, pix_fn(3, 0), 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, 1, pix_fn(3, 1), 1'b0, 1'b0, "R3");
        step(1'b0, 1'b1, 2, pix_fn(3, 2), 1'b0, 1'b0, "R3");
        rd_only("R3 capture of idx 2");
        for (int i = 3; i < 8; i++) step(1'b0, 1'b1, i, pix_fn(3, i), 1'b0, 1'b0, "R3");
        rd_only("R3 no second capture in frame");

        // R9: pixel on the frame-start cycle is captured
        step(1'b1, 1'b1, 3, 7'h55, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b0, 0, '0, 1'b0, 1'b0, "R9");
        rd_only("R9 pixel with frame start");

        // R4: held across later frames
        frame(5, "R4");
        frame(6, "R4");
        step(1'b0, 1'b1, 5, 7'h2a, 1'b0, 1'b0, "R4");
        rd_only("R4 first capture held");

        // R8: write with read in same cycle, then blocked for rest of frame
        frame(7, "R8");
        step(1'b0, 1'b0, 0, '0, 1'b1, 1'b1, "R8 read during write shows held pixel");
        step(1'b0, 1'b1, 0, 7'h33, 1'b0, 1'b0, "R8");
        rd_only("R8 no capture before next frame");
        frame(8, "R8");
        rd_only("R8 restart at pixel 0");

        // R7: full upload across the 224 -> 0 wrap
        for (int k = 0; k < NUM_PIX; k++) begin
            frame(20 + k, "R7");
            rd_only("R7 upload and wrap");
        end
        frame(300, "R7");
        rd_only("R7 after wrap");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule